// File: doc/BRIEF.md
# Bit-Sequential Carrier Register

This block is a 16-bit holding register that a processor reaches through a narrow bus in three widths. It can read or write a single bit, one of four nibbles, or one of two bytes. A width code and a direct address input choose the field. Bit 0 is the least significant bit of the register.

It also has a second path for bit-serial work. A 4-bit position pointer selects one bit. That bit can be read or written through dedicated pins. The pointer can be loaded, or stepped up or down by one after each access, so software can walk all sixteen bits of a word in either direction without computing addresses.

Top module: `bsc_reg`

## Requirements
- R1: While `rst_n` is low, the register content and the pointer are all zero.
- R2: With `acc_size` = 0 (bit), `acc_addr[3:0]` selects a bit. A write stores `wr_data[0]` there, and a read returns that bit in `rd_data[0]`, with the upper bits zero.
- R3: With `acc_size` = 1 (nibble), `acc_addr[1:0]` selects the nibble at bits `4*n+3..4*n`. A write stores `wr_data[3:0]`, and a read returns the nibble zero-extended to 8 bits.
- R4: With `acc_size` = 2 (byte), `acc_addr[0]` selects the low byte (0) or the high byte (1). A write stores `wr_data`, and a read returns that byte.
- R5: `rd_data` and `bit_rd` are combinational views of the current content. A write becomes visible only after the next rising clock edge.
- R6: `bit_rd` always shows the bit selected by `ptr`. With `bit_wr_en` high, the next edge stores `bit_wr_val` at that position.
- R7: With `ptr_step` high and `ptr_load` low, the pointer moves by one at the edge. It counts up when `ptr_dir` = 0 and down when `ptr_dir` = 1, wrapping modulo 16 both ways. With neither `ptr_step` nor `ptr_load` high, it holds.
- R8: `ptr_load` loads `ptr_load_val` and takes priority over `ptr_step`.
- R9: A bit write and a pointer step in the same cycle write at the pointer value from before the step.
- R10: `acc_size` = 3 is reserved. A write with that code changes nothing, and a read with it returns zero.
- R11: If a bus write and an indirect bit write hit the same cycle, the indirect bit write wins on its bit. The bus write applies to the rest of its field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_size | input | 2 | Bus access width: 0 bit, 1 nibble, 2 byte, 3 reserved |
| acc_addr | input | 4 | Direct address of the selected field |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data, right-aligned |
| rd_data | output | 8 | Bus read data, right-aligned, zero-extended |
| ptr_load | input | 1 | Load the pointer from `ptr_load_val` |
| ptr_load_val | input | 4 | Pointer load value |
| ptr_step | input | 1 | Step the pointer by one |
| ptr_dir | input | 1 | Step direction: 0 up, 1 down |
| ptr | output | 4 | Current pointer value |
| bit_wr_en | input | 1 | Write `bit_wr_val` at the pointed bit |
| bit_wr_val | input | 1 | Indirect write bit |
| bit_rd | output | 1 | Bit at the pointed position |

## Verification
Every read is due in the same cycle its address and width are applied, because `rd_data` and `bit_rd` involve no register. Every write and every pointer change is due one rising edge after the strobe. The bench changes inputs on the falling edge. It checks reads shortly after that, before the next rising edge, so each check sees the state left by exactly the earlier edges. For R5 it also checks that a freshly written value has not yet appeared before its edge. Pointer checks come one edge after the step or load.

// File: rtl/bsc_reg.sv
module bsc_reg #(
  parameter int W  = 16,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            acc_size,
  input  logic [$clog2(W)-1:0]  acc_addr,
  input  logic                  wr_en,
  input  logic [DW-1:0]         wr_data,
  output logic [DW-1:0]         rd_data,
  input  logic                  ptr_load,
  input  logic [$clog2(W)-1:0]  ptr_load_val,
  input  logic                  ptr_step,
  input  logic                  ptr_dir,
  output logic [$clog2(W)-1:0]  ptr,
  input  logic                  bit_wr_en,
  input  logic                  bit_wr_val,
  output logic                  bit_rd
);
  localparam int PW = $clog2(W);
  localparam int NW = $clog2(W / 4);
  localparam int BW = (W / DW > 1) ? $clog2(W / DW) : 1;
  localparam logic [1:0] SZ_BIT = 2'd0, SZ_NIB = 2'd1, SZ_BYTE = 2'd2;

  logic [W-1:0]  data, data_nxt;
  logic [PW-1:0] ptr_nxt;
  logic [NW-1:0] nib_sel;
  logic [BW-1:0] byte_sel;

  assign nib_sel  = acc_addr[NW-1:0];
  assign byte_sel = acc_addr[BW-1:0];
  assign bit_rd   = data[ptr];

  always_comb begin
    data_nxt = data;
    if (wr_en) begin
      case (acc_size)
        SZ_BIT:  data_nxt[acc_addr] = wr_data[0];
        SZ_NIB:  data_nxt[{nib_sel, 2'b00} +: 4] = wr_data[3:0];
        SZ_BYTE: data_nxt[{byte_sel, 3'b000} +: 8] = wr_data[7:0];
        default: ;
      endcase
    end
    if (bit_wr_en) data_nxt[ptr] = bit_wr_val;
  end

  always_comb begin
    rd_data = '0;
    case (acc_size)
      SZ_BIT:  rd_data[0]   = data[acc_addr];
      SZ_NIB:  rd_data[3:0] = data[{nib_sel, 2'b00} +: 4];
      SZ_BYTE: rd_data[7:0] = data[{byte_sel, 3'b000} +: 8];
      default: ;
    endcase
  end

  always_comb begin
    if (ptr_load)      ptr_nxt = ptr_load_val;
    else if (ptr_step) ptr_nxt = ptr_dir ? ptr - 1'b1 : ptr + 1'b1;
    else               ptr_nxt = ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      ptr  <= '0;
    end else begin
      data <= data_nxt;
      ptr  <= ptr_nxt;
    end
  end
endmodule

// File: rtl/bsc_reg_chk.sv
module bsc_reg_chk #(
  parameter int W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           acc_size,
  input logic                 wr_en,
  input logic                 ptr_load,
  input logic [$clog2(W)-1:0] ptr_load_val,
  input logic                 ptr_step,
  input logic                 ptr_dir,
  input logic [$clog2(W)-1:0] ptr,
  input logic                 bit_wr_en,
  input logic                 bit_wr_val,
  input logic [W-1:0]         data
);
  localparam int PW = $clog2(W);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (ptr == '0 && data == '0));

  p_ptr_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && !ptr_load && !ptr_dir) |=> ptr == PW'($past(ptr) + 1'b1));

  p_ptr_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && !ptr_load && ptr_dir) |=> ptr == PW'($past(ptr) - 1'b1));

  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_step && !ptr_load) |=> $stable(ptr));

  p_ptr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> ptr == $past(ptr_load_val));

  p_bit_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr_en |=> data[$past(ptr)] == $past(bit_wr_val));

  p_reserved_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_size == 2'd3 && !bit_wr_en) |=> $stable(data));

  p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !bit_wr_en) |=> $stable(data));
endmodule

bind bsc_reg bsc_reg_chk #(.W(W)) u_chk (.*);

// File: tb/bsc_reg_tb.sv
module bsc_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] acc_size = '0;
  logic [3:0] acc_addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       ptr_load = 1'b0;
  logic [3:0] ptr_load_val = '0;
  logic       ptr_step = 1'b0;
  logic       ptr_dir = 1'b0;
  logic [3:0] ptr;
  logic       bit_wr_en = 1'b0;
  logic       bit_wr_val = 1'b0;
  logic       bit_rd;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bsc_reg u_dut (.*);

  // vector: [14:13] size, [12:9] addr, [8] write, [7:0] write data or expected read
  localparam int NV = 13;
  localparam logic [14:0] VEC [NV] = '{
    {2'd2, 4'd0, 1'b1, 8'hA5},
    {2'd2, 4'd0, 1'b0, 8'hA5},
    {2'd1, 4'd3, 1'b1, 8'h0C},
    {2'd2, 4'd1, 1'b0, 8'hC0},
    {2'd0, 4'd9, 1'b1, 8'h01},
    {2'd1, 4'd2, 1'b0, 8'h02},
    {2'd0, 4'd15, 1'b0, 8'h01},
    {2'd0, 4'd1, 1'b0, 8'h00},
    {2'd2, 4'd1, 1'b1, 8'h3E},
    {2'd1, 4'd3, 1'b0, 8'h03},
    {2'd1, 4'd0, 1'b0, 8'h05},
    {2'd0, 4'd0, 1'b1, 8'h00},
    {2'd2, 4'd0, 1'b0, 8'hA4}
  };

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sz, input logic [3:0] a, input int exp, input string req);
    @(negedge clk);
    acc_size = sz; acc_addr = a; wr_en = 1'b0;
    #1 check(req, rd_data, exp);
  endtask

  task automatic wr(input logic [1:0] sz, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_size = sz; acc_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ptr_op(input logic ld, input logic [3:0] v, input logic st, input logic dn);
    @(negedge clk);
    ptr_load = ld; ptr_load_val = v; ptr_step = st; ptr_dir = dn;
    @(negedge clk);
    ptr_load = 1'b0; ptr_step = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    pat = 16'h9C3B;
    #1;
    check("R1 ptr", ptr, 0);
    acc_size = 2'd2; acc_addr = 4'd1; #1 check("R1 byte1", rd_data, 0);
    acc_addr = 4'd0; #1 check("R1 byte0", rd_data, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][8]) begin
        @(negedge clk);
        acc_size = VEC[i][14:13]; acc_addr = VEC[i][12:9];
        wr_data = VEC[i][7:0]; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
      end else begin
        rd(VEC[i][14:13], VEC[i][12:9], VEC[i][7:0], "R2/R3/R4 vector");
      end
    end

    // R5: write not visible before the edge
    @(negedge clk);
    acc_size = 2'd2; acc_addr = 4'd0; wr_data = 8'h5A; wr_en = 1'b1;
    #1 check("R5 before edge", rd_data, 8'hA4);
    @(negedge clk);
    wr_en = 1'b0;
    #1 check("R5 after edge", rd_data, 8'h5A);

    // R8: load beats step
    ptr_op(1'b1, 4'd14, 1'b1, 1'b0);
    check("R8 load priority", ptr, 14);

    // R6/R9: walk up with write and step in same cycle, wrapping
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      bit_wr_en = 1'b1; bit_wr_val = pat[(14 + i) % 16];
      ptr_step = 1'b1; ptr_dir = 1'b0;
    end
    @(negedge clk);
    bit_wr_en = 1'b0; ptr_step = 1'b0;
    check("R7 full wrap up", ptr, 14);
    rd(2'd2, 4'd0, pat[7:0], "R9 walked low byte");
    rd(2'd2, 4'd1, pat[15:8], "R9 walked high byte");

    ptr_op(1'b0, 4'd0, 1'b1, 1'b0);
    ptr_op(1'b0, 4'd0, 1'b1, 1'b0);
    check("R7 wrap 15->0", ptr, 0);
    ptr_op(1'b0, 4'd0, 1'b1, 1'b1);
    check("R7 wrap 0->15", ptr, 15);
    ptr_op(1'b0, 4'd0, 1'b0, 1'b0);
    check("R7 hold", ptr, 15);

    // R6: indirect read walking down
    for (int i = 15; i >= 0; i--) begin
      #1 check("R6 bit_rd walk down", bit_rd, pat[i]);
      if (i > 0) ptr_op(1'b0, 4'd0, 1'b1, 1'b1);
    end

    // R11: bus byte write and indirect bit write in same cycle
    ptr_op(1'b1, 4'd3, 1'b0, 1'b0);
    @(negedge clk);
    acc_size = 2'd2; acc_addr = 4'd0; wr_data = 8'h00; wr_en = 1'b1;
    bit_wr_en = 1'b1; bit_wr_val = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; bit_wr_en = 1'b0;
    rd(2'd2, 4'd0, 8'h08, "R11 indirect wins");

    // R10: reserved size
    wr(2'd3, 4'd1, 8'hFF);
    rd(2'd2, 4'd1, pat[15:8], "R10 write ignored");
    rd(2'd3, 4'd0, 0, "R10 read zero");

    // R2: bit read of high address
    wr(2'd0, 4'd14, 8'h01);
    rd(2'd0, 4'd14, 1, "R2 bit 14 set");
    rd(2'd1, 4'd3, {1'b1, 1'b1, pat[13:12]}, "R3 nibble3 after bit");

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 reset ptr", ptr, 0);
    acc_size = 2'd2; acc_addr = 4'd1; #1 check("R1 reset data", rd_data, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule